// File: doc/BRIEF.md
# Sticky Status and Interrupt Controller

This block collects event flags from an ADC and level conditions from three supply monitors into one 24-bit status word. Once set, a bit stays set. An active-high interrupt is raised when any set bit is not masked. A host reads the status word over a simple register bus. Completing that read clears the word, but each source has its own rule for what survives the clear. While a read is in flight, new events are parked in a pending register and merged into the status word once the read is over, so no event is lost and none is cleared before the host has seen it.

Six bit positions are used. Bit 0 is the low-threshold core-supply monitor, bit 1 the high-threshold core-supply monitor, bit 2 the analog-supply monitor, bit 3 conversion done, bit 4 FIFO threshold and bit 5 accumulator full. Bits 23..6 are reserved. A separate data-ready pin tells the host that an unread conversion result is waiting. If a new result overwrites a result that has not been read, the pin goes low for one clock.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with idle inputs, `status` reads 0x000007, meaning the three monitor bits are set. `irq` is 0, `data_rdy` is 0 and the interrupt mask is all ones.
- R2: `irq` equals the OR of (status AND NOT mask) over bits 5..0, taken from the status and mask values one clock earlier. Bits 23..6 of `status` always read 0.
- R3: An event for a bit that is already set leaves the bit set. It never toggles the bit.
- R4: A cycle with `rd_busy` or `rd_status` high is a hold cycle. In a hold cycle, events go into a pending register and do not reach `status`. `rd_status` completes a status read and clears the word, subject to R5. Pending events appear in `status` one clock after the first cycle in which both `rd_busy` and `rd_status` are low.
- R5: Monitor bit i (0..2) sets when `mon_en[i]` and `mon_fault[i]` are both high. A status read leaves it set only if both are still high in the read cycle. Otherwise the read clears it.
- R6: While `mon_en[i]` is low, monitor bit i cannot go from 0 to 1, including from a pending event. A bit that is already set holds its value until a status read.
- R7: Bit 3 sets one clock after an `adc_done` pulse. It clears on `rd_adc_data` or on a status read.
- R8: Bit 4 sets on `fifo_thr` and clears on `rd_fifo` or `wr_fifo`. Bit 5 sets on `acc_full` and clears on `rd_acc` or `wr_acc`. Outside hold cycles, an event in the same cycle as its clear wins.
- R9: After `adc_done`, `data_rdy` goes high on the next clock. `rd_adc_data` or `rd_status` drives it low. If `adc_done` arrives while `data_rdy` is high, `data_rdy` is low for exactly one clock and then high again.
- R10: When `mask_we` is high, `mask_wdata` is loaded into the mask, and `irq` follows the new mask one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mon_fault | input | 3 | Undervoltage level from each supply monitor |
| mon_en | input | 3 | Enable (powered) flag of each supply monitor |
| adc_done | input | 1 | Pulse: conversion result written to the data register |
| fifo_thr | input | 1 | Pulse: FIFO write reached the threshold address |
| acc_full | input | 1 | Pulse: accumulator reached its programmed count |
| rd_status | input | 1 | Strobe: a status read completes this cycle |
| rd_busy | input | 1 | Level: a status read is in progress |
| rd_adc_data | input | 1 | Strobe: ADC data register read |
| rd_fifo | input | 1 | Strobe: FIFO register read |
| wr_fifo | input | 1 | Strobe: FIFO register write |
| rd_acc | input | 1 | Strobe: accumulator register read |
| wr_acc | input | 1 | Strobe: accumulator register write |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 24 | New mask value, 1 = source masked |
| status | output | 24 | Current status word |
| irq | output | 1 | Active-high interrupt |
| data_rdy | output | 1 | Unread conversion result available |

## Verification
A corrupted status or pending bit appears on `status` one clock after the cycle that should have set or cleared it, and on `irq` one clock after that. A pending register that lost or leaked an event therefore shows up within one cycle after a read window closes. A wrong data-ready state shows up on `data_rdy` in the clock right after the `adc_done` or read that should have moved it. A one-clock gap that is missing or stretched is caught in the next two cycles. Every cycle, the bench compares `status`, `irq` and `data_rdy` against a model of the requirements, so a divergence is reported on the clock it first appears.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int STAT_W_DEF  = 24;
  localparam int NUM_MON_DEF = 3;
  localparam int NUM_ADC_EV  = 3;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_VALID = 2'd1,
    DR_GAP   = 2'd2
  } drdy_state_e;
endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/stat_event_reg.sv
module stat_event_reg #(
  parameter int STAT_W  = 24,
  parameter int NUM_MON = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_fault,
  input  logic [NUM_MON-1:0] mon_en,
  input  logic               ev_done,
  input  logic               ev_fifo,
  input  logic               ev_acc,
  input  logic               clr_done,
  input  logic               clr_fifo,
  input  logic               clr_acc,
  input  logic               hold,
  input  logic               rd_status,
  output logic [STAT_W-1:0]  status
);
  localparam int NS     = NUM_MON + status_pkg::NUM_ADC_EV;
  localparam int DONE_B = NUM_MON;
  localparam int FIFO_B = NUM_MON + 1;
  localparam int ACC_B  = NUM_MON + 2;
  localparam logic [NS-1:0] STAT_RST = {{status_pkg::NUM_ADC_EV{1'b0}}, {NUM_MON{1'b1}}};

  logic [NS-1:0] stat_q, stat_d;
  logic [NS-1:0] pend_q, pend_d;
  logic [NS-1:0] ev_vec, keep_vec, side_clr, apply_en;
  logic          upd_en;

  always_comb begin
    ev_vec                 = '0;
    ev_vec[NUM_MON-1:0]    = mon_fault & mon_en;
    ev_vec[DONE_B]         = ev_done;
    ev_vec[FIFO_B]         = ev_fifo;
    ev_vec[ACC_B]          = ev_acc;
    keep_vec               = '0;
    keep_vec[NUM_MON-1:0]  = mon_fault & mon_en;
    side_clr               = '0;
    side_clr[DONE_B]       = clr_done;
    side_clr[FIFO_B]       = clr_fifo;
    side_clr[ACC_B]        = clr_acc;
    apply_en               = '1;
    apply_en[NUM_MON-1:0]  = mon_en;
  end

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    if (hold) begin
      pend_d = pend_q | ev_vec;
      if (rd_status) stat_d = stat_q & keep_vec;
      stat_d = stat_d & ~side_clr;
    end else begin
      stat_d = (stat_q & ~side_clr) | ev_vec | (pend_q & apply_en);
      pend_d = '0;
    end
    upd_en = hold | (|ev_vec) | (|pend_q) | (|side_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      pend_q <= '0;
    end else if (upd_en) begin
      stat_q <= stat_d;
      pend_q <= pend_d;
    end
  end

  for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bits
    if (gi < NS) begin : g_live
      assign status[gi] = stat_q[gi];
    end else begin : g_rsv
      assign status[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/stat_drdy_gen.sv
module stat_drdy_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic new_data,
  input  logic consume,
  output logic data_rdy
);
  import status_pkg::*;

  drdy_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DR_IDLE:  if (new_data) state_d = DR_VALID;
      DR_VALID: begin
        if (new_data)     state_d = DR_GAP;
        else if (consume) state_d = DR_IDLE;
      end
      DR_GAP:   state_d = DR_VALID;
      default:  state_d = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DR_IDLE;
    else        state_q <= state_d;
  end

  assign data_rdy = (state_q == DR_VALID);
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
  parameter int STAT_W = 24,
  parameter int NUM_SRC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  localparam logic [STAT_W-1:0] SRC_MASK = STAT_W'((64'd1 << NUM_SRC) - 64'd1);

  logic [STAT_W-1:0] mask_q, mask_d;
  logic              irq_q, irq_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    irq_d  = |(status & ~mask_q & SRC_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import status_pkg::*;
#(
  parameter int STAT_W      = STAT_W_DEF,
  parameter int NUM_MON     = NUM_MON_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_fault,
  input  logic [NUM_MON-1:0] mon_en,
  input  logic               adc_done,
  input  logic               fifo_thr,
  input  logic               acc_full,
  input  logic               rd_status,
  input  logic               rd_busy,
  input  logic               rd_adc_data,
  input  logic               rd_fifo,
  input  logic               wr_fifo,
  input  logic               rd_acc,
  input  logic               wr_acc,
  input  logic               mask_we,
  input  logic [STAT_W-1:0]  mask_wdata,
  output logic [STAT_W-1:0]  status,
  output logic               irq,
  output logic               data_rdy
);
  localparam int NUM_SRC = NUM_MON + NUM_ADC_EV;

  logic              rst_core_n;
  logic              hold;
  logic [STAT_W-1:0] mask_vec;

  assign hold = rd_busy | rd_status;

  stat_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_core_n)
  );

  stat_event_reg #(.STAT_W(STAT_W), .NUM_MON(NUM_MON)) u_evreg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .mon_fault (mon_fault),
    .mon_en    (mon_en),
    .ev_done   (adc_done),
    .ev_fifo   (fifo_thr),
    .ev_acc    (acc_full),
    .clr_done  (rd_adc_data),
    .clr_fifo  (rd_fifo | wr_fifo),
    .clr_acc   (rd_acc | wr_acc),
    .hold      (hold),
    .rd_status (rd_status),
    .status    (status)
  );

  stat_drdy_gen u_drdy (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .new_data (adc_done),
    .consume  (rd_adc_data | rd_status),
    .data_rdy (data_rdy)
  );

  stat_irq_gen #(.STAT_W(STAT_W), .NUM_SRC(NUM_SRC)) u_irq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .status     (status),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask       (mask_vec),
    .irq        (irq)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int STAT_W  = 24,
  parameter int NUM_MON = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_MON-1:0] mon_fault,
  input logic [NUM_MON-1:0] mon_en,
  input logic               adc_done,
  input logic               rd_status,
  input logic               rd_busy,
  input logic               rd_adc_data,
  input logic               rd_fifo,
  input logic               wr_fifo,
  input logic               rd_acc,
  input logic               wr_acc,
  input logic               mask_we,
  input logic [STAT_W-1:0]  mask_wdata,
  input logic [STAT_W-1:0]  mask,
  input logic [STAT_W-1:0]  status,
  input logic               irq,
  input logic               data_rdy
);
  localparam int NS = NUM_MON + 3;
  localparam int DB = NUM_MON;
  localparam logic [STAT_W-1:0] SRCM = STAT_W'((64'd1 << NS) - 64'd1);

  logic side_any;
  assign side_any = rd_adc_data | rd_fifo | wr_fifo | rd_acc | wr_acc;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(status) & ~$past(mask) & SRCM))); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[DB] && !rd_status && !rd_adc_data) |=> status[DB]); // R3

  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_status && !side_any) |=> $stable(status)); // R4

  AST_MON_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status[NUM_MON-1:0] & $past(status[NUM_MON-1:0] & mon_en & mon_fault)) == '0)); // R5

  AST_MON_NO_SET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[NUM_MON-1:0] & ~$past(mon_en) & ~$past(status[NUM_MON-1:0])) == '0)); // R6

  AST_DRDY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rdy && adc_done) |=> (!data_rdy ##1 data_rdy)); // R9

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(mask_wdata))); // R10
endmodule

bind irq_status_ctrl irq_status_chk #(.STAT_W(STAT_W), .NUM_MON(NUM_MON)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .mon_fault   (mon_fault),
  .mon_en      (mon_en),
  .adc_done    (adc_done),
  .rd_status   (rd_status),
  .rd_busy     (rd_busy),
  .rd_adc_data (rd_adc_data),
  .rd_fifo     (rd_fifo),
  .wr_fifo     (wr_fifo),
  .rd_acc      (rd_acc),
  .wr_acc      (wr_acc),
  .mask_we     (mask_we),
  .mask_wdata  (mask_wdata),
  .mask        (mask_vec),
  .status      (status),
  .irq         (irq),
  .data_rdy    (data_rdy)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mon_fault, mon_en;
  logic        adc_done, fifo_thr, acc_full;
  logic        rd_status, rd_busy, rd_adc_data, rd_fifo, wr_fifo, rd_acc, wr_acc;
  logic        mask_we;
  logic [23:0] mask_wdata;
  logic [23:0] status;
  logic        irq, data_rdy;

  int n_run = 0;
  int n_fail = 0;

  logic [5:0]  m_st, m_pend;
  logic [23:0] m_mask;
  logic        m_irq;
  int          m_dr;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mon_fault(mon_fault), .mon_en(mon_en),
    .adc_done(adc_done), .fifo_thr(fifo_thr), .acc_full(acc_full),
    .rd_status(rd_status), .rd_busy(rd_busy), .rd_adc_data(rd_adc_data),
    .rd_fifo(rd_fifo), .wr_fifo(wr_fifo), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .status(status), .irq(irq), .data_rdy(data_rdy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    adc_done = 0; fifo_thr = 0; acc_full = 0;
    rd_status = 0; rd_busy = 0; rd_adc_data = 0;
    rd_fifo = 0; wr_fifo = 0; rd_acc = 0; wr_acc = 0;
    mask_we = 0; mask_wdata = '0;
  endtask

  function automatic int dr_next(int cur, logic done, logic consume);
    if (cur == 0) return done ? 1 : 0;
    if (cur == 1) return done ? 2 : (consume ? 0 : 1);
    return 1;
  endfunction

  // one clock: inputs are set at negedge, model advances, outputs compared at next negedge
  task automatic step(input string tag);
    logic [5:0] ev, keep, side, nst, npend;
    logic       hold, nirq;
    int         ndr;
    ev   = {acc_full, fifo_thr, adc_done, mon_fault & mon_en};
    keep = {3'b000, mon_fault & mon_en};
    side = {rd_acc | wr_acc, rd_fifo | wr_fifo, rd_adc_data, 3'b000};
    hold = rd_busy | rd_status;
    if (hold) begin
      npend = m_pend | ev;
      nst   = (rd_status ? (m_st & keep) : m_st) & ~side;
    end else begin
      nst   = (m_st & ~side) | ev | (m_pend & {3'b111, mon_en});
      npend = '0;
    end
    nirq = |(m_st & ~m_mask[5:0]);
    ndr  = dr_next(m_dr, adc_done, rd_adc_data | rd_status);
    @(posedge clk);
    m_st = nst; m_pend = npend; m_irq = nirq; m_dr = ndr;
    if (mask_we) m_mask = mask_wdata;
    @(negedge clk);
    check(tag, {8'h0, status}, {8'h0, 18'h0, m_st});
    check("R2 irq", {31'h0, irq}, {31'h0, m_irq});
    check("R9 data_rdy", {31'h0, data_rdy}, {31'h0, (m_dr == 1)});
    idle_in();
  endtask

  task automatic status_read(input string tag);
    rd_busy = 1; step(tag);
    rd_busy = 1; rd_status = 1; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_in();
    mon_fault = 0; mon_en = 3'b111;
    rst_n = 0;
    m_st = 6'h07; m_pend = 0; m_mask = '1; m_irq = 0; m_dr = 0;
    repeat (3) @(negedge clk);
    check("R1 status reset", {8'h0, status}, 32'h7);
    check("R1 irq reset", {31'h0, irq}, 0);
    check("R1 data_rdy reset", {31'h0, data_rdy}, 0);
    rst_n = 1;
    repeat (4) step("R1 idle after reset");

    // monitors clear on first read with healthy supplies
    status_read("R5 power-up read");
    step("R5 monitors cleared");
    check("R5 status zero", {8'h0, status}, 0);

    // monitor keeps while fault persists
    mon_fault = 3'b010; step("R5 fault sets");
    mon_fault = 3'b010; rd_busy = 1; step("R5 fault during read");
    mon_fault = 3'b010; rd_busy = 1; rd_status = 1; step("R5 read keeps active fault");
    mon_fault = 3'b000; step("R5 pending applied");
    status_read("R5 read after fault gone");
    step("R5 bit cleared");

    // disabled monitor
    mon_en = 3'b011; mon_fault = 3'b100;
    repeat (3) step("R6 disabled cannot set");
    mon_en = 3'b111; step("R6 enabled sets");
    mon_en = 3'b011; mon_fault = 3'b000;
    repeat (2) step("R6 disabled holds");
    check("R6 bit2 held", {31'h0, status[2]}, 1);
    mon_en = 3'b011; status_read("R6 read clears disabled");
    mon_en = 3'b111; step("R6 after read");

    // mask and irq
    mask_we = 1; mask_wdata = 24'hFFFFF7; step("R10 mask write");
    adc_done = 1; step("R7 done sets");
    step("R10 irq rises");
    check("R10 irq unmasked", {31'h0, irq}, 1);
    adc_done = 1; step("R3 repeat done sticky");
    step("R9 gap over");
    rd_adc_data = 1; step("R7 data read clears");
    adc_done = 1; rd_adc_data = 1; step("R8 set wins over clear");

    fifo_thr = 1; acc_full = 1; step("R8 fifo and acc set");
    wr_fifo = 1; step("R8 fifo write clears");
    rd_acc = 1; step("R8 acc read clears");
    acc_full = 1; step("R8 acc set again");
    wr_acc = 1; step("R8 acc write clears");

    // deferral
    rd_busy = 1; fifo_thr = 1; step("R4 held during read");
    check("R4 fifo not visible", {31'h0, status[4]}, 0);
    rd_busy = 1; rd_status = 1; acc_full = 1; step("R4 read completes");
    step("R4 pending applied");
    check("R4 deferred events visible", {26'h0, status[5:4]}, 2'b11);

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int rlen;
      if ($urandom_range(0, 19) == 0) begin
        rlen = $urandom_range(1, 4);
        for (int k = 0; k < rlen; k++) begin
          rd_busy = 1;
          rd_status = (k == rlen - 1);
          adc_done = ($urandom_range(0, 5) == 0);
          fifo_thr = ($urandom_range(0, 5) == 0);
          acc_full = ($urandom_range(0, 5) == 0);
          step("R4 random read");
        end
      end else begin
        if ($urandom_range(0, 15) == 0) mon_fault = 3'($urandom);
        if ($urandom_range(0, 31) == 0) mon_en = 3'($urandom);
        adc_done    = ($urandom_range(0, 6) == 0);
        fifo_thr    = ($urandom_range(0, 8) == 0);
        acc_full    = ($urandom_range(0, 8) == 0);
        rd_adc_data = ($urandom_range(0, 6) == 0);
        rd_fifo     = ($urandom_range(0, 12) == 0);
        wr_fifo     = ($urandom_range(0, 12) == 0);
        rd_acc      = ($urandom_range(0, 12) == 0);
        wr_acc      = ($urandom_range(0, 12) == 0);
        if ($urandom_range(0, 40) == 0) begin
          mask_we = 1; mask_wdata = 24'($urandom);
        end
        step("R3 random status");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule